// File: doc/BRIEF.md
# Prefixed Opcode Length and Cycle Predecoder

This block watches an instruction byte stream for an 8-bit accumulator machine, one byte per cycle in which `in_valid` is high. It finds where each instruction starts and ends. When the last byte of an instruction has been taken, it reports the opcode, the addressing mode, the total byte count and the execution cycle count for that instruction. A fetch unit or a trace decoder can use these results to size its prefetch or to account for time, without decoding the whole instruction set.

The supported subset is the 8-bit add, add-with-carry and AND groups for both accumulators, the 16-bit add to the double accumulator, and the inherent register adds. In these groups the high opcode nibble selects the addressing mode, and each mode has a fixed operand size. A page prefix byte of 0x18 in front of an indexed opcode switches the index register from X to Y. The prefix adds one byte to the length and one cycle to the timing. Any other byte is reported as an illegal instruction, and the next byte starts a new instruction.

Top module: `pd_predecoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is low. After reset the first accepted byte is treated as the start of an instruction.
- R2: Opcodes with low nibble 0x4, 0x9 or 0xB are 8-bit ops on accumulator A when the high nibble is 0x8 (immediate, mode 1), 0x9 (direct, mode 2), 0xB (extended, mode 3) or 0xA (X-indexed, mode 4). The length is 2, 2, 3 and 2 bytes.
- R3: The same low nibbles with high nibble 0xC, 0xD, 0xF or 0xE are the accumulator-B forms. They use the same modes and lengths.
- R4: The 16-bit add opcodes 0xC3, 0xD3, 0xF3 and 0xE3 take modes 1, 2, 3 and 4. The immediate form carries two operand bytes, so the length is 3. The cycle counts are 4, 5, 6 and 6.
- R5: 8-bit ops take 2 cycles immediate, 3 direct, 4 extended and 4 X-indexed.
- R6: Prefix 0x18 before an indexed opcode reports mode 5 (Y-indexed). The length is 3, with one more cycle than the X form: 5 for 8-bit ops and 7 for the 16-bit add.
- R7: Inherent ops report mode 0. 0x1B gives length 1 and 2 cycles. 0x3A gives length 1 and 3 cycles. 0x18 0x3A gives length 2 and 4 cycles, with opcode 0x3A.
- R8: An unprefixed byte outside the subset completes at once. It reports illegal high, length 1, mode 0 and 0 cycles, and the next byte starts a new instruction.
- R9: A prefix followed by a non-indexed or unsupported opcode completes on that second byte. It reports illegal high, length 2, mode 0, 0 cycles, and the second byte as the opcode.
- R10: Cycles with `in_valid` low change no parser state and produce no result. An instruction split by stalls reports the same result as one sent without gaps.
- R11: `out_valid` pulses for one cycle, in the cycle after the final byte of an instruction is accepted, and never after a non-final byte. The result fields change only in that cycle and hold between results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A stream byte is present this cycle |
| in_byte | input | 8 | Stream byte |
| out_valid | output | 1 | One-cycle pulse: a result is ready |
| out_opcode | output | 8 | Opcode byte of the completed instruction (prefix excluded) |
| out_mode | output | 3 | 0 inherent, 1 immediate, 2 direct, 3 extended, 4 X-indexed, 5 Y-indexed |
| out_len | output | 3 | Total bytes, prefix included |
| out_cycles | output | 4 | Execution cycles (0 when illegal) |
| out_illegal | output | 1 | Opcode outside the subset |

## Verification
The assertions check, on every cycle, the rules that tie the outputs together. No result follows a stalled cycle. The result fields change only together with a pulse. Extended and Y-indexed results always have length 3. Y-indexed results always take 5 or 7 cycles. Illegal results are always inherent with no cycles. Only the bench's scenarios can show that each opcode maps to the right mode and cycle count, that the prefix is charged exactly once, and that the parser resynchronises after illegal bytes and after stalls in the middle of an instruction.

// File: rtl/predec_pkg.sv
package predec_pkg;
    localparam int unsigned CODE_W = 8;
    localparam int unsigned LEN_W  = 3;
    localparam int unsigned CYC_W  = 4;

    typedef enum logic [2:0] {
        MODE_INH = 3'd0,
        MODE_IMM = 3'd1,
        MODE_DIR = 3'd2,
        MODE_EXT = 3'd3,
        MODE_IDX = 3'd4,
        MODE_IDY = 3'd5
    } mode_t;

    typedef enum logic [1:0] {
        P_HEAD  = 2'd0,
        P_PAGED = 2'd1,
        P_OPER  = 2'd2
    } pstate_t;
endpackage

// File: rtl/pd_classify.sv
module pd_classify
    import predec_pkg::*;
#(
    parameter logic [CODE_W-1:0] ABA_CODE = 8'h1B,
    parameter logic [CODE_W-1:0] ABX_CODE = 8'h3A
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              paged_i,
    output logic              legal_o,
    output mode_t             mode_o,
    output logic              wide_o,
    output logic              abx_o,
    output logic [1:0]        ops_o
);
    logic [3:0] hi, lo;
    logic       grp8, grp16;
    mode_t      mem_mode;

    always_comb begin
        hi    = code_i[7:4];
        lo    = code_i[3:0];
        grp8  = hi[3] && (lo == 4'h4 || lo == 4'h9 || lo == 4'hB);
        grp16 = (hi[3:2] == 2'b11) && (lo == 4'h3);
        case (hi[1:0])
            2'b00:   mem_mode = MODE_IMM;
            2'b01:   mem_mode = MODE_DIR;
            2'b10:   mem_mode = MODE_IDX;
            default: mem_mode = MODE_EXT;
        endcase

        legal_o = 1'b0;
        mode_o  = MODE_INH;
        wide_o  = 1'b0;
        abx_o   = 1'b0;
        if (code_i == ABX_CODE) begin
            legal_o = 1'b1;
            abx_o   = 1'b1;
        end else if (!paged_i && code_i == ABA_CODE) begin
            legal_o = 1'b1;
        end else if (grp8 || grp16) begin
            legal_o = !paged_i || (mem_mode == MODE_IDX);
            wide_o  = grp16 && legal_o;
            if (legal_o) mode_o = (paged_i) ? MODE_IDY : mem_mode;
        end

        case (mode_o)
            MODE_IMM: ops_o = wide_o ? 2'd2 : 2'd1;
            MODE_DIR: ops_o = 2'd1;
            MODE_EXT: ops_o = 2'd2;
            MODE_IDX: ops_o = 2'd1;
            MODE_IDY: ops_o = 2'd1;
            default:  ops_o = 2'd0;
        endcase
    end
endmodule

// File: rtl/pd_timing.sv
module pd_timing
    import predec_pkg::*;
(
    input  mode_t            mode_i,
    input  logic             wide_i,
    input  logic             abx_i,
    input  logic             paged_i,
    output logic [CYC_W-1:0] cyc_o
);
    logic [CYC_W-1:0] base;

    always_comb begin
        case (mode_i)
            MODE_IMM: base = CYC_W'(2);
            MODE_DIR: base = CYC_W'(3);
            MODE_EXT: base = CYC_W'(4);
            MODE_IDX: base = CYC_W'(4);
            MODE_IDY: base = CYC_W'(5);
            default:  base = CYC_W'(2) + CYC_W'(abx_i) + CYC_W'(paged_i);
        endcase
        cyc_o = base + (wide_i ? CYC_W'(2) : CYC_W'(0));
    end
endmodule

// File: rtl/pd_predecoder.sv
module pd_predecoder
    import predec_pkg::*;
#(
    parameter logic [CODE_W-1:0] PAGE_CODE = 8'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] in_byte,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_opcode,
    output logic [2:0]        out_mode,
    output logic [LEN_W-1:0]  out_len,
    output logic [CYC_W-1:0]  out_cycles,
    output logic              out_illegal
);
    typedef struct packed {
        pstate_t           st;
        logic              paged;
        logic [CODE_W-1:0] opc;
        mode_t             mode;
        logic [1:0]        rem;
        logic [LEN_W-1:0]  len;
        logic [CYC_W-1:0]  cyc;
        logic              ov;
        logic [CODE_W-1:0] o_opc;
        mode_t             o_mode;
        logic [LEN_W-1:0]  o_len;
        logic [CYC_W-1:0]  o_cyc;
        logic              o_ill;
    } state_t;

    state_t state_d, state_q;

    logic             cls_paged;
    logic             cls_legal;
    mode_t            cls_mode;
    logic             cls_wide;
    logic             cls_abx;
    logic [1:0]       cls_ops;
    logic [CYC_W-1:0] cls_cyc;
    logic [LEN_W-1:0] len_now;

    assign cls_paged = (state_q.st == P_PAGED);

    pd_classify cls_i (
        .code_i  (in_byte),
        .paged_i (cls_paged),
        .legal_o (cls_legal),
        .mode_o  (cls_mode),
        .wide_o  (cls_wide),
        .abx_o   (cls_abx),
        .ops_o   (cls_ops)
    );

    pd_timing tim_i (
        .mode_i  (cls_mode),
        .wide_i  (cls_wide),
        .abx_i   (cls_abx),
        .paged_i (cls_paged),
        .cyc_o   (cls_cyc)
    );

    assign len_now = LEN_W'(1) + LEN_W'(cls_paged) + LEN_W'(cls_ops);

    always_comb begin
        state_d    = state_q;
        state_d.ov = 1'b0;
        if (in_valid) begin
            if (state_q.st == P_OPER) begin
                state_d.rem = state_q.rem - 2'd1;
                if (state_q.rem == 2'd1) begin
                    state_d.st     = P_HEAD;
                    state_d.paged  = 1'b0;
                    state_d.ov     = 1'b1;
                    state_d.o_opc  = state_q.opc;
                    state_d.o_mode = state_q.mode;
                    state_d.o_len  = state_q.len;
                    state_d.o_cyc  = state_q.cyc;
                    state_d.o_ill  = 1'b0;
                end
            end else if (state_q.st == P_HEAD && in_byte == PAGE_CODE) begin
                state_d.st    = P_PAGED;
                state_d.paged = 1'b1;
            end else if (!cls_legal) begin
                state_d.st     = P_HEAD;
                state_d.paged  = 1'b0;
                state_d.ov     = 1'b1;
                state_d.o_opc  = in_byte;
                state_d.o_mode = MODE_INH;
                state_d.o_len  = LEN_W'(1) + LEN_W'(cls_paged);
                state_d.o_cyc  = '0;
                state_d.o_ill  = 1'b1;
            end else if (cls_ops == 2'd0) begin
                state_d.st     = P_HEAD;
                state_d.paged  = 1'b0;
                state_d.ov     = 1'b1;
                state_d.o_opc  = in_byte;
                state_d.o_mode = cls_mode;
                state_d.o_len  = len_now;
                state_d.o_cyc  = cls_cyc;
                state_d.o_ill  = 1'b0;
            end else begin
                state_d.st   = P_OPER;
                state_d.opc  = in_byte;
                state_d.mode = cls_mode;
                state_d.len  = len_now;
                state_d.cyc  = cls_cyc;
                state_d.rem  = cls_ops;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign out_valid   = state_q.ov;
    assign out_opcode  = state_q.o_opc;
    assign out_mode    = state_q.o_mode;
    assign out_len     = state_q.o_len;
    assign out_cycles  = state_q.o_cyc;
    assign out_illegal = state_q.o_ill;
endmodule

// File: rtl/pd_predecoder_chk.sv
module pd_predecoder_chk
    import predec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [CODE_W-1:0] out_opcode,
    input logic [2:0]        out_mode,
    input logic [LEN_W-1:0]  out_len,
    input logic [CYC_W-1:0]  out_cycles,
    input logic              out_illegal
);
    a_r10_no_result_after_stall: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r11_fields_move_with_pulse: assert property (@(posedge clk) disable iff (rst)
        (!$stable(out_opcode) || !$stable(out_len) || !$stable(out_cycles)) |-> out_valid);

    a_r2_extended_len: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mode == 3'd3) |-> out_len == LEN_W'(3));

    a_r6_y_indexed_shape: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mode == 3'd5) |->
            (out_len == LEN_W'(3) && (out_cycles == CYC_W'(5) || out_cycles == CYC_W'(7))));

    a_r8_illegal_shape: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |->
            (out_mode == 3'd0 && out_cycles == '0 && out_len <= LEN_W'(2)));

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);
endmodule

bind pd_predecoder pd_predecoder_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_opcode  (out_opcode),
    .out_mode    (out_mode),
    .out_len     (out_len),
    .out_cycles  (out_cycles),
    .out_illegal (out_illegal)
);

// File: tb/pd_predecoder_tb.sv
`timescale 1ns/1ps
module pd_predecoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [7:0] out_opcode;
    logic [2:0] out_mode;
    logic [2:0] out_len;
    logic [3:0] out_cycles;
    logic       out_illegal;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pd_predecoder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_opcode(out_opcode), .out_mode(out_mode),
        .out_len(out_len), .out_cycles(out_cycles), .out_illegal(out_illegal)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'hFF;
            @(posedge clk);
            #1;
            check("R10", "no pulse while stalled", out_valid, 0);
        end
    endtask

    task automatic instr(string req, int n, logic [7:0] b0, logic [7:0] b1,
                         logic [7:0] b2, logic [7:0] b3, logic [7:0] opc,
                         int mode, int len, int cyc, int ill);
        logic [7:0] seq [4];
        seq[0] = b0; seq[1] = b1; seq[2] = b2; seq[3] = b3;
        for (int i = 0; i < n; i++) begin
            push(seq[i]);
            if (i < n - 1) check("R11", "no pulse mid-instruction", out_valid, 0);
        end
        check(req, "out_valid", out_valid, 1);
        check(req, "opcode", out_opcode, opc);
        check(req, "mode", out_mode, mode);
        check(req, "length", out_len, len);
        check(req, "cycles", out_cycles, cyc);
        check(req, "illegal", out_illegal, ill);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R1", "out_valid in reset", out_valid, 0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk);
        #1 check("R1", "out_valid after reset", out_valid, 0);
        instr("R1", 1, 8'h1B, 0, 0, 0, 8'h1B, 0, 1, 2, 0);
    endtask

    task automatic t_acc_a();
        instr("R2", 2, 8'h89, 8'h55, 0, 0, 8'h89, 1, 2, 2, 0);
        instr("R2", 2, 8'h94, 8'h10, 0, 0, 8'h94, 2, 2, 3, 0);
        instr("R2", 3, 8'hBB, 8'h12, 8'h34, 0, 8'hBB, 3, 3, 4, 0);
        instr("R5", 2, 8'hA9, 8'h07, 0, 0, 8'hA9, 4, 2, 4, 0);
    endtask

    task automatic t_acc_b();
        instr("R3", 2, 8'hC4, 8'h0F, 0, 0, 8'hC4, 1, 2, 2, 0);
        instr("R3", 2, 8'hD9, 8'h20, 0, 0, 8'hD9, 2, 2, 3, 0);
        instr("R3", 3, 8'hFB, 8'h18, 8'h18, 0, 8'hFB, 3, 3, 4, 0);
        instr("R5", 2, 8'hEB, 8'h00, 0, 0, 8'hEB, 4, 2, 4, 0);
    endtask

    task automatic t_wide();
        instr("R4", 3, 8'hC3, 8'h12, 8'h34, 0, 8'hC3, 1, 3, 4, 0);
        instr("R4", 2, 8'hD3, 8'h40, 0, 0, 8'hD3, 2, 2, 5, 0);
        instr("R4", 3, 8'hF3, 8'hAB, 8'hCD, 0, 8'hF3, 3, 3, 6, 0);
        instr("R4", 2, 8'hE3, 8'h02, 0, 0, 8'hE3, 4, 2, 6, 0);
    endtask

    task automatic t_prefix();
        instr("R6", 3, 8'h18, 8'hA9, 8'h05, 0, 8'hA9, 5, 3, 5, 0);
        instr("R6", 3, 8'h18, 8'hE4, 8'h18, 0, 8'hE4, 5, 3, 5, 0);
        instr("R6", 3, 8'h18, 8'hE3, 8'h01, 0, 8'hE3, 5, 3, 7, 0);
    endtask

    task automatic t_inherent();
        instr("R7", 1, 8'h1B, 0, 0, 0, 8'h1B, 0, 1, 2, 0);
        instr("R7", 1, 8'h3A, 0, 0, 0, 8'h3A, 0, 1, 3, 0);
        instr("R7", 2, 8'h18, 8'h3A, 0, 0, 8'h3A, 0, 2, 4, 0);
    endtask

    task automatic t_illegal();
        instr("R8", 1, 8'h00, 0, 0, 0, 8'h00, 0, 1, 0, 1);
        instr("R8", 1, 8'h83, 0, 0, 0, 8'h83, 0, 1, 0, 1);
        instr("R8", 2, 8'h89, 8'h01, 0, 0, 8'h89, 1, 2, 2, 0);
        instr("R9", 2, 8'h18, 8'h89, 0, 0, 8'h89, 0, 2, 0, 1);
        instr("R9", 2, 8'h18, 8'h1B, 0, 0, 8'h1B, 0, 2, 0, 1);
        instr("R9", 2, 8'h18, 8'h18, 0, 0, 8'h18, 0, 2, 0, 1);
        instr("R9", 2, 8'h94, 8'h33, 0, 0, 8'h94, 2, 2, 3, 0);
    endtask

    task automatic t_stall();
        push(8'h18);
        idle(2);
        push(8'hE3);
        check("R10", "no pulse mid-instruction", out_valid, 0);
        idle(3);
        push(8'h7F);
        check("R10", "out_valid", out_valid, 1);
        check("R10", "mode", out_mode, 5);
        check("R10", "length", out_len, 3);
        check("R10", "cycles", out_cycles, 7);
        idle(2);
        check("R11", "opcode held", out_opcode, 8'hE3);
        check("R11", "length held", out_len, 3);
        push(8'hB4);
        push(8'h01);
        idle(1);
        push(8'h02);
        check("R10", "extended after stall", out_len, 3);
        check("R10", "extended cycles", out_cycles, 4);
    endtask

    initial begin
        t_reset();
        t_acc_a();
        t_acc_b();
        t_wide();
        t_prefix();
        t_inherent();
        t_illegal();
        t_stall();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule